// File: doc/BRIEF.md
# Pulse-Width Capture Timer Channel

This block is a single timer channel that measures how long an already synchronized input stays high, or stays low. It samples a free-running time-base count at the edge that opens a pulse and again at the edge that closes it. When a complete pulse has been seen it raises a sticky flag. Software then reads two data ports: one returns the closing-edge count and the other returns the opening-edge count. The width is the first value minus the second, taken modulo the time-base width.

Four internal registers hold the counts. A leading stage holds the opening count of the pulse in progress. A trailing register holds the closing count. A coherent shadow holds the opening count that belongs to the latest closing count. An output register feeds the B data port. The read strobes have side effects on these registers. Together they make sure that the two values software reads belong to the same pulse, even when the reads are cycles apart and new pulses arrive between them. Software never has to lock anything.

Top module: `pwcap_channel`

## Requirements
- R1: After reset, dataA and dataB are zero and flag is 0. All four capture and staging registers reset to zero, and B-port transfers start enabled.
- R2: When polSel is 1 a rising edge of sigIn opens the pulse and a falling edge closes it. When polSel is 0 a falling edge opens the pulse and a rising edge closes it.
- R3: Closing-edge captures are ignored while enable is low, and after enable goes high until the first opening edge has been captured. Deasserting enable disarms the channel again.
- R4: On a closing edge the trailing register (dataA) loads timeBase, the shadow loads the leading stage, and flag is set. dataB loads the leading stage when transfers are enabled. All these outputs are visible one clock after the edge.
- R5: While flag is set, each further closing edge still overwrites the trailing register, the shadow and (if enabled) dataB, and flag stays set.
- R6: A one-cycle readA strobe loads dataB from the shadow at the next clock and blocks leading-stage to dataB transfers on later closing edges.
- R7: A one-cycle readB strobe loads dataB from the shadow at the next clock and re-enables transfers, starting from the next closing edge.
- R8: Leading-stage to shadow transfers are never blocked, so a readB after a blocked period returns the opening count of the newest pulse.
- R9: A one-cycle flagClr strobe clears flag at the next clock. If a closing edge is seen in the same cycle, flag stays set.
- R10: An opening edge loads the leading stage with timeBase and changes neither flag nor either data port.
- R11: When readA and readB arrive together, dataB loads from the shadow and transfers end up blocked.
- R12: With the sequence 0x1000 (open), 0x1100 (close), 0x1250 (open), 0x1525 (close), dataA/dataB read 0x1100/0x1000 after the first pulse and 0x1525/0x1250 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; low disarms closing-edge capture |
| polSel | input | 1 | 1: measure high pulse, 0: measure low pulse |
| sigIn | input | 1 | Synchronized input signal |
| timeBase | input | TB_W | Free-running count to capture |
| readA | input | 1 | One-cycle strobe: A data port was read |
| readB | input | 1 | One-cycle strobe: B data port was read |
| flagClr | input | 1 | One-cycle write-1-to-clear strobe for flag |
| dataA | output | TB_W | Closing-edge capture |
| dataB | output | TB_W | Opening-edge capture, coherent with dataA |
| flag | output | 1 | Sticky pulse-complete flag |

## Verification
The bench builds the channel with TB_W = 16. The sample counts then fit in the port, and a pulse that spans the counter roll-over (opening at 0xFFF0 and closing at 0x0010) can be reached in a few cycles. A behavioural model of the registers is compared on every clock. Directed sequences cover both polarities, reads interleaved with new pulses, simultaneous reads, and a clear strobe that coincides with a closing edge.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic capLead;   // leading stage <= timeBase
    logic capTrail;  // trailing <= timeBase, shadow <= leading stage
    logic b1FromA1;  // output register <= shadow (read side effect)
    logic b1FromB2;  // output register <= leading stage (closing edge)
  } capStrobes_t;
endpackage

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        polSel,
  input  logic        sigIn,
  input  logic        readA,
  input  logic        readB,
  input  logic        flagClr,
  output capStrobes_t strobes,
  output logic        flag
);
  logic sigPrev;
  logic armed;
  logic xferEn;
  logic riseEdge, fallEdge;
  logic leadEdge, trailEdge;

  assign riseEdge  = sigIn & ~sigPrev;
  assign fallEdge  = ~sigIn & sigPrev;
  assign leadEdge  = enable & (polSel ? riseEdge : fallEdge);
  assign trailEdge = enable & armed & (polSel ? fallEdge : riseEdge);

  always_comb begin
    strobes          = '0;
    strobes.capLead  = leadEdge;
    strobes.capTrail = trailEdge;
    strobes.b1FromA1 = readA | readB;
    strobes.b1FromB2 = trailEdge & xferEn & ~(readA | readB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigPrev <= 1'b0;
      armed   <= 1'b0;
      xferEn  <= 1'b1;
      flag    <= 1'b0;
    end else begin
      sigPrev <= sigIn;
      if (!enable)       armed <= 1'b0;
      else if (leadEdge) armed <= 1'b1;
      if (readA)         xferEn <= 1'b0;
      else if (readB)    xferEn <= 1'b1;
      if (trailEdge)     flag <= 1'b1;
      else if (flagClr)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwcap_datapath.sv
module pwcap_datapath
  import pwcap_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  capStrobes_t     strobes,
  input  logic [TB_W-1:0] timeBase,
  output logic [TB_W-1:0] a2Q,
  output logic [TB_W-1:0] a1Q,
  output logic [TB_W-1:0] b1Q
);
  logic [TB_W-1:0] b2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b2Q <= '0;
      a2Q <= '0;
      a1Q <= '0;
      b1Q <= '0;
    end else begin
      if (strobes.capLead) b2Q <= timeBase;
      if (strobes.capTrail) begin
        a2Q <= timeBase;
        a1Q <= b2Q;
      end
      if (strobes.b1FromA1)      b1Q <= a1Q;
      else if (strobes.b1FromB2) b1Q <= b2Q;
    end
  end
endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel
  import pwcap_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            polSel,
  input  logic            sigIn,
  input  logic [TB_W-1:0] timeBase,
  input  logic            readA,
  input  logic            readB,
  input  logic            flagClr,
  output logic [TB_W-1:0] dataA,
  output logic [TB_W-1:0] dataB,
  output logic            flag
);
  capStrobes_t     strobes;
  logic [TB_W-1:0] a1Q;

  pwcap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .polSel(polSel), .sigIn(sigIn),
    .readA(readA), .readB(readB), .flagClr(flagClr),
    .strobes(strobes), .flag(flag)
  );

  pwcap_datapath #(.TB_W(TB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timeBase(timeBase),
    .a2Q(dataA), .a1Q(a1Q), .b1Q(dataB)
  );
endmodule

// File: rtl/pwcap_checker.sv
module pwcap_checker #(
  parameter int TB_W = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            readA,
  input logic            readB,
  input logic            flagClr,
  input logic [TB_W-1:0] timeBase,
  input logic [TB_W-1:0] dataA,
  input logic [TB_W-1:0] dataB,
  input logic [TB_W-1:0] shadowA1,
  input logic            flag
);
  // R4: a rising flag carries the count sampled at the closing edge
  p_trail_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> dataA == $past(timeBase));

  // R4/R10: the trailing register moves only together with a set flag
  p_dataA_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataA) |-> flag);

  // R5: flag is sticky without a clear strobe
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    flag && !flagClr |=> flag);

  // R9: flag falls only after a clear strobe
  p_flag_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(flagClr));

  // R3: no capture completes while disabled
  p_no_trail_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(flag));

  // R6/R7: any read refreshes dataB from the shadow
  p_read_loads_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    readA || readB |=> dataB == $past(shadowA1));
endmodule

bind pwcap_channel pwcap_checker #(.TB_W(TB_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .readA(readA), .readB(readB),
  .flagClr(flagClr), .timeBase(timeBase), .dataA(dataA), .dataB(dataB),
  .shadowA1(a1Q), .flag(flag)
);

// File: tb/pwcap_channel_test.sv
module pwcap_channel_test;
  localparam int TB_W = 16;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b0;
  logic            polSel = 1'b1;
  logic            sigIn = 1'b0;
  logic [TB_W-1:0] timeBase = '0;
  logic            readA = 1'b0;
  logic            readB = 1'b0;
  logic            flagClr = 1'b0;
  logic [TB_W-1:0] dataA, dataB;
  logic            flag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  pwcap_channel #(.TB_W(TB_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .polSel(polSel), .sigIn(sigIn),
    .timeBase(timeBase), .readA(readA), .readB(readB), .flagClr(flagClr),
    .dataA(dataA), .dataB(dataB), .flag(flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mB2, mA2, mA1, mB1;
  bit mArmed, mXfer, mFlag, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mB2 = 0; mA2 = 0; mA1 = 0; mB1 = 0;
      mArmed = 0; mXfer = 1; mFlag = 0; mPrev = 0;
    end else begin
      bit rise, fall, lead, trail;
      int oB2, oA1;
      rise = sigIn && !mPrev;
      fall = !sigIn && mPrev;
      lead = enable && (polSel ? rise : fall);
      trail = enable && mArmed && (polSel ? fall : rise);
      oB2 = mB2; oA1 = mA1;
      if (lead) mB2 = int'(timeBase);
      if (trail) begin mA2 = int'(timeBase); mA1 = oB2; end
      if (readA || readB) mB1 = oA1;
      else if (trail && mXfer) mB1 = oB2;
      if (readA) mXfer = 0; else if (readB) mXfer = 1;
      if (trail) mFlag = 1; else if (flagClr) mFlag = 0;
      if (!enable) mArmed = 0; else if (lead) mArmed = 1;
      mPrev = sigIn;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4 model dataA", int'(dataA), mA2);
      check("R7 model dataB", int'(dataB), mB1);
      check("R5 model flag", int'(flag), int'(mFlag));
    end
  end

  task automatic step(input bit s, input int tb, input bit ra, input bit rb, input bit clr);
    sigIn = s; timeBase = TB_W'(tb); readA = ra; readB = rb; flagClr = clr;
    @(posedge clk);
    @(negedge clk);
    readA = 0; readB = 0; flagClr = 0;
  endtask

  task automatic pulse(input int tOpen, input int tClose);
    step(polSel, tOpen, 0, 0, 0);
    step(!polSel, tClose, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset dataA", int'(dataA), 0);
    check("R1 reset dataB", int'(dataB), 0);
    check("R1 reset flag", int'(flag), 0);

    // R3: input high while disabled, then closing edge before any opening edge
    polSel = 1;
    step(1, 'h0100, 0, 0, 0);
    enable = 1;
    step(1, 'h0200, 0, 0, 0);
    step(0, 'h0300, 0, 0, 0);
    check("R3 unarmed flag", int'(flag), 0);
    check("R3 unarmed dataA", int'(dataA), 0);

    // R10: opening edge alone
    step(1, 'h1000, 0, 0, 0);
    check("R10 lead flag", int'(flag), 0);
    check("R10 lead dataB", int'(dataB), 0);
    step(0, 'h1100, 0, 0, 0);
    check("R12 first dataA", int'(dataA), 'h1100);
    check("R12 first dataB", int'(dataB), 'h1000);
    check("R4 flag set", int'(flag), 1);

    pulse('h1250, 'h1525);
    check("R12 second dataA", int'(dataA), 'h1525);
    check("R12 second dataB", int'(dataB), 'h1250);
    check("R5 flag stays", int'(flag), 1);

    // R6: readA blocks transfers
    step(0, 'h1600, 1, 0, 0);
    check("R6 readA dataB", int'(dataB), 'h1250);
    pulse('h2000, 'h2100);
    check("R6 blocked dataA", int'(dataA), 'h2100);
    check("R6 blocked dataB", int'(dataB), 'h1250);

    // R8: shadow kept updating, readB returns newest
    step(0, 'h2200, 0, 1, 0);
    check("R8 readB dataB", int'(dataB), 'h2000);
    pulse('h3000, 'h3300);
    check("R7 reenabled dataB", int'(dataB), 'h3000);

    // R9: clear and set-wins
    step(0, 'h3400, 0, 0, 1);
    check("R9 clear flag", int'(flag), 0);
    step(1, 'h3500, 0, 0, 0);
    step(0, 'h3600, 0, 0, 1);
    check("R9 set wins", int'(flag), 1);

    // R2: negative pulse with polSel=0
    enable = 0;
    step(1, 'h3700, 0, 0, 0);
    polSel = 0;
    enable = 1;
    step(1, 'h3800, 0, 0, 0);
    pulse('h4000, 'h4080);
    check("R2 neg dataA", int'(dataA), 'h4080);
    check("R2 neg dataB", int'(dataB), 'h4000);

    // R11: simultaneous reads leave transfers blocked
    step(1, 'h4100, 1, 1, 0);
    check("R11 both reads dataB", int'(dataB), 'h4000);
    pulse('h5000, 'h5010);
    check("R11 blocked dataB", int'(dataB), 'h4000);
    step(1, 'h5020, 0, 1, 0);
    check("R11 after readB dataB", int'(dataB), 'h5000);

    // roll-over pulse
    pulse('hFFF0, 'h0010);
    check("R4 wrap dataA", int'(dataA), 'h0010);
    check("R4 wrap dataB", int'(dataB), 'hFFF0);
    check("R4 wrap width", int'(TB_W'(dataA - dataB)), 'h0020);

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule